// File: doc/BRIEF.md
# ISA Bus Cycle Timing Generator

This block shapes the strobes of one ISA bus cycle after the local bus has decided to run it. A request names the kind of cycle (I/O, 8-bit memory or 16-bit memory), the direction, and whether the addressed slave is 16 bits wide. The block then drives an address-latch pulse, a read or write command and a ready pulse back to the processor side. All timing is counted in half periods of the ISA bus clock, each `HALF_CLKS` core clocks long. The half-step counter restarts with every cycle, so strobes are placed relative to the request.

Two small configuration registers hold the per-kind command delays, the per-width wait-state codes and an address-hold option. They are copied into the cycle when it starts. During the cycle the slave may keep IOCHRDY low to stretch the command, or pull its zero-wait-state line low to finish early.

Top module: `isa_cycle_timer`

## Requirements
- R1: After reset all strobes are low and the registers hold the defaults: register 0 (address 0) = 0x05, register 1 (address 1) = 0x06. That means command delay 1 for I/O and 8-bit memory, 0 for 16-bit memory, wait-state code 2 for 8-bit slaves and 1 for 16-bit slaves, and address hold off.
- R2: `ale` is high for exactly the first half-step (`HALF_CLKS` clocks) of each cycle, and never together with a command or ready.
- R3: Command delay d comes from register 0: bits [1:0] for I/O (kind 0), [3:2] for 8-bit memory (kind 1), [5:4] for 16-bit memory (kind 2). The command asserts at half-step 1+d. If that would fall after the last command half-step, it asserts on the last command half-step.
- R4: Register 1 bits [1:0] give 8-bit slaves w = code+2 wait states. Bits [3:2] give 16-bit slaves w = code. The last command half-step is 2+2w, whatever the command delay.
- R5: After one idle half-step that follows the command, `cpu_rdy` pulses high for exactly one clock.
- R6: While `iochrdy` is low at the half-step boundary ending the last command half-step, the command stays asserted. It ends at the first boundary where `iochrdy` is high.
- R7: When `nows_n` is low at a half-step boundary after at least one command-active half-step, the command ends there. At earlier boundaries `nows_n` has no effect.
- R8: When `iochrdy` is low, `nows_n` low does not shorten the cycle.
- R9: With register 1 bit [4] set, `cpu_rdy` comes one clock later.
- R10: Register writes during a cycle do not change that cycle's timing. They take effect from the next cycle.
- R11: `req_write` high gives `cmd_wr`, low gives `cmd_rd`. The two are never high together.
- R12: A request while a cycle is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst | input | 1 | synchronous active-high reset |
| cfg_we | input | 1 | register write strobe |
| cfg_addr | input | 1 | register select (0 delays, 1 waits/hold) |
| cfg_wdata | input | 8 | register write data |
| req | input | 1 | cycle request, taken when idle |
| req_kind | input | 2 | 0 I/O, 1 8-bit memory, 2 16-bit memory |
| req_write | input | 1 | 1 write, 0 read |
| req_slv16 | input | 1 | slave is 16 bits wide |
| iochrdy | input | 1 | slave ready, low stretches |
| nows_n | input | 1 | slave zero-wait request, active low |
| ale | output | 1 | address latch pulse |
| cmd_rd | output | 1 | read command, active high |
| cmd_wr | output | 1 | write command, active high |
| cpu_rdy | output | 1 | one-clock ready to processor |

## Verification
The hardest situation to reach is a zero-wait request that arrives while IOCHRDY is low. The stretch must win, and the early end must still be refused before the command has been on for a half-step. The stimulus holds both slave lines active from before the request and releases IOCHRDY at a chosen clock. The resulting command end and ready clock are then compared with values derived from the half-step rules. A register write placed in the middle of a running cycle, and a second request issued while busy, cover the cases where inputs must be ignored.

// File: rtl/isa_tim_pkg.sv
package isa_tim_pkg;

  localparam int HW = 4;

  typedef enum logic [1:0] {
    KIND_IO    = 2'd0,
    KIND_MEM8  = 2'd1,
    KIND_MEM16 = 2'd2
  } cyc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2,
    ST_RDY  = 2'd3
  } seq_st_e;

  typedef struct packed {
    logic       addr_hold;
    logic [1:0] ws16_code;
    logic [1:0] ws8_code;
    logic [1:0] cd_m16;
    logic [1:0] cd_m8;
    logic [1:0] cd_io;
  } tim_cfg_t;

  localparam tim_cfg_t CFG_DEFAULT = '{
    addr_hold: 1'b0, ws16_code: 2'd1, ws8_code: 2'd2,
    cd_m16: 2'd0, cd_m8: 2'd1, cd_io: 2'd1
  };

endpackage

// File: rtl/isa_cfg_regs.sv
module isa_cfg_regs
  import isa_tim_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output tim_cfg_t          cfg
);

  logic [DATA_W-1:0] unused_wdata;
  assign unused_wdata = wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= CFG_DEFAULT;
    end else if (we) begin
      if (!addr) begin
        cfg.cd_io  <= wdata[1:0];
        cfg.cd_m8  <= wdata[3:2];
        cfg.cd_m16 <= wdata[5:4];
      end else begin
        cfg.ws8_code  <= wdata[1:0];
        cfg.ws16_code <= wdata[3:2];
        cfg.addr_hold <= wdata[4];
      end
    end
  end

  initial assert (DATA_W >= 6) else $error("config data too narrow");

endmodule

// File: rtl/isa_half_step.sv
module isa_half_step #(
  parameter int HALF_CLKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic step
);

  localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CLKS - 1);

  logic [CW-1:0] cnt;

  generate
    if (HALF_CLKS == 1) begin : g_direct
      assign step = en;
      always_ff @(posedge clk) cnt <= '0;
    end else begin : g_count
      assign step = en && (cnt == LAST);
      always_ff @(posedge clk) begin
        if (rst || clr || step) cnt <= '0;
        else if (en)            cnt <= cnt + 1'b1;
      end
    end
  endgenerate

  logic unused_rst_cnt;
  assign unused_rst_cnt = rst & (|cnt);

endmodule

// File: rtl/isa_cycle_seq.sv
module isa_cycle_seq
  import isa_tim_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  tim_cfg_t cfg,
  input  logic     req,
  input  logic [1:0] req_kind,
  input  logic     req_write,
  input  logic     req_slv16,
  input  logic     iochrdy,
  input  logic     nows_n,
  input  logic     step,
  output logic     start,
  output logic     running,
  output logic     ale_o,
  output logic     rd_o,
  output logic     wr_o,
  output logic     rdy_o
);

  seq_st_e st_q, nst;
  logic [HW-1:0] h_q, nh, beg_q, nbeg, end_q, nend;
  logic          wr_q, nwr, hold_q, nhold;

  logic [1:0]    cd_sel;
  logic [2:0]    ws_sel;
  logic [HW-1:0] end_new, beg_raw, beg_new;
  logic          cmd_next;

  always_comb begin
    case (req_kind)
      KIND_IO:   cd_sel = cfg.cd_io;
      KIND_MEM8: cd_sel = cfg.cd_m8;
      default:   cd_sel = cfg.cd_m16;
    endcase
    ws_sel  = req_slv16 ? {1'b0, cfg.ws16_code} : ({1'b0, cfg.ws8_code} + 3'd2);
    end_new = HW'(2) + HW'({ws_sel, 1'b0});
    beg_raw = HW'(1) + HW'(cd_sel);
    beg_new = (beg_raw > end_new) ? end_new : beg_raw;
  end

  assign start   = (st_q == ST_IDLE) && req;
  assign running = (st_q == ST_RUN);

  always_comb begin
    nst   = st_q;
    nh    = h_q;
    nbeg  = beg_q;
    nend  = end_q;
    nwr   = wr_q;
    nhold = hold_q;
    case (st_q)
      ST_IDLE: if (req) begin
        nst   = ST_RUN;
        nh    = '0;
        nbeg  = beg_new;
        nend  = end_new;
        nwr   = req_write;
        nhold = cfg.addr_hold;
      end
      ST_RUN: if (step) begin
        if (h_q == end_q) begin
          if (iochrdy) nh = end_q + 1'b1;
        end else if (h_q > end_q) begin
          nst = hold_q ? ST_HOLD : ST_RDY;
        end else if (h_q >= beg_q && !nows_n && iochrdy) begin
          nh = end_q + 1'b1;
        end else begin
          nh = h_q + 1'b1;
        end
      end
      ST_HOLD: nst = ST_RDY;
      default: nst = ST_IDLE;
    endcase
  end

  assign cmd_next = (nst == ST_RUN) && (nh >= nbeg) && (nh <= nend);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      h_q    <= '0;
      beg_q  <= '0;
      end_q  <= '0;
      wr_q   <= 1'b0;
      hold_q <= 1'b0;
      ale_o  <= 1'b0;
      rd_o   <= 1'b0;
      wr_o   <= 1'b0;
      rdy_o  <= 1'b0;
    end else begin
      st_q   <= nst;
      h_q    <= nh;
      beg_q  <= nbeg;
      end_q  <= nend;
      wr_q   <= nwr;
      hold_q <= nhold;
      ale_o  <= (nst == ST_RUN) && (nh == '0);
      rd_o   <= cmd_next && !nwr;
      wr_o   <= cmd_next && nwr;
      rdy_o  <= (nst == ST_RDY);
    end
  end

  assert_cmd_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(rd_o && wr_o));

  assert_ale_alone_R2: assert property (@(posedge clk) disable iff (rst)
    ale_o |-> (!rd_o && !wr_o && !rdy_o));

  assert_rdy_single_R5: assert property (@(posedge clk) disable iff (rst)
    rdy_o |=> !rdy_o);

  assert_stretch_R6: assert property (@(posedge clk) disable iff (rst)
    (running && step && h_q == end_q && !iochrdy && (rd_o || wr_o)) |=> (rd_o || wr_o));

  assert_prio_R8: assert property (@(posedge clk) disable iff (rst)
    (running && step && h_q < end_q && !iochrdy) |=> (running && h_q == $past(h_q) + 1'b1));

  assert_busy_ignore_R12: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE && st_q != ST_RDY && req) |=> !(ale_o && !$past(ale_o)));

endmodule

// File: rtl/isa_cycle_timer.sv
module isa_cycle_timer
  import isa_tim_pkg::*;
#(
  parameter int HALF_CLKS = 2,
  parameter int CFG_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             req,
  input  logic [1:0]       req_kind,
  input  logic             req_write,
  input  logic             req_slv16,
  input  logic             iochrdy,
  input  logic             nows_n,
  output logic             ale,
  output logic             cmd_rd,
  output logic             cmd_wr,
  output logic             cpu_rdy
);

  tim_cfg_t cfg;
  logic     step, start, running;

  isa_cfg_regs #(.DATA_W(CFG_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .cfg(cfg)
  );

  isa_half_step #(.HALF_CLKS(HALF_CLKS)) u_step (
    .clk(clk), .rst(rst), .clr(start), .en(running), .step(step)
  );

  isa_cycle_seq u_seq (
    .clk(clk), .rst(rst), .cfg(cfg),
    .req(req), .req_kind(req_kind), .req_write(req_write), .req_slv16(req_slv16),
    .iochrdy(iochrdy), .nows_n(nows_n), .step(step),
    .start(start), .running(running),
    .ale_o(ale), .rd_o(cmd_rd), .wr_o(cmd_wr), .rdy_o(cpu_rdy)
  );

endmodule

// File: tb/sim_isa_cycle_timer.sv
module sim_isa_cycle_timer;

  localparam int P = 2;

  logic clk = 0, rst = 1;
  logic cfg_we = 0, cfg_addr = 0;
  logic [7:0] cfg_wdata = 0;
  logic req = 0, req_write = 0, req_slv16 = 0, iochrdy = 1, nows_n = 1;
  logic [1:0] req_kind = 0;
  logic ale, cmd_rd, cmd_wr, cpu_rdy;

  always #5 clk = ~clk;

  isa_cycle_timer #(.HALF_CLKS(P), .CFG_W(8)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req(req), .req_kind(req_kind), .req_write(req_write), .req_slv16(req_slv16),
    .iochrdy(iochrdy), .nows_n(nows_n),
    .ale(ale), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cpu_rdy(cpu_rdy)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int b_r0 = 8'h05, b_r1 = 8'h06;
  int m_ale, m_ale_late, m_first, m_last, m_rdy, m_rdycnt, m_rd, m_wr;

  // vector: {kind[1:0], write, slv16, reg0[7:0], reg1[7:0]}
  localparam logic [19:0] VEC [6] = '{
    {2'd0, 1'b0, 1'b0, 8'h05, 8'h06},
    {2'd2, 1'b1, 1'b1, 8'h05, 8'h06},
    {2'd1, 1'b0, 1'b0, 8'h3C, 8'h00},
    {2'd0, 1'b1, 1'b1, 8'h03, 8'h00},
    {2'd2, 1'b0, 1'b1, 8'h20, 8'h1C},
    {2'd1, 1'b1, 1'b0, 8'h00, 8'h13}
  };

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic wcfg(input logic a, input int d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_we = 0;
    if (a) b_r1 = d; else b_r0 = d;
  endtask

  // expected values from the bench's own register mirror
  task automatic expect_t(input int kind, input int s16, output int first, output int last,
                          output int rdy, output int endh, output int beg, output int hold);
    int cd, ws;
    cd = (kind == 0) ? (b_r0 & 3) : (kind == 1) ? ((b_r0 >> 2) & 3) : ((b_r0 >> 4) & 3);
    ws = s16 ? ((b_r1 >> 2) & 3) : ((b_r1 & 3) + 2);
    hold = (b_r1 >> 4) & 1;
    endh = 2 + 2 * ws;
    beg = (1 + cd > endh) ? endh : 1 + cd;
    first = beg * P;
    last = (endh + 1) * P - 1;
    rdy = (endh + 2) * P + hold;
  endtask

  task automatic run_cycle(input int kind, input int wrt, input int s16, input int rel_x,
                           input int nows, input int busy_req, input int midw);
    m_ale = 0; m_ale_late = 0; m_first = -1; m_last = -1; m_rdy = -1;
    m_rdycnt = 0; m_rd = 0; m_wr = 0;
    @(negedge clk);
    iochrdy = (rel_x < 0);
    nows_n = !nows[0];
    req = 1; req_kind = 2'(kind); req_write = wrt[0]; req_slv16 = s16[0];
    for (int t = 0; t < 150; t++) begin
      @(negedge clk);
      if (ale) begin if (t < P) m_ale++; else m_ale_late++; end
      if (cmd_rd || cmd_wr) begin
        if (m_first < 0) m_first = t;
        m_last = t;
      end
      if (cmd_rd) m_rd++;
      if (cmd_wr) m_wr++;
      if (cpu_rdy) begin m_rdycnt++; if (m_rdy < 0) m_rdy = t; end
      req = (busy_req != 0 && t == 2);
      if (t == rel_x) iochrdy = 1;
      if (midw != 0 && t == 2) begin cfg_we = 1; cfg_addr = 1; cfg_wdata = 8'h13; end
      else cfg_we = 0;
      if (m_rdy >= 0 && t >= m_rdy + 4) break;
    end
    req = 0; iochrdy = 1; nows_n = 1; cfg_we = 0;
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d expected <50000 cycles", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin : main
    int ef, el, er, eh, eb, ho;
    repeat (3) @(negedge clk);
    // R1: reset state of the strobes
    chk("R1 ale in reset", int'(ale), 0);
    chk("R1 cmd in reset", int'(cmd_rd | cmd_wr), 0);
    chk("R1 rdy in reset", int'(cpu_rdy), 0);
    rst = 0;

    // R1: defaults used with no register write
    expect_t(0, 0, ef, el, er, eh, eb, ho);
    run_cycle(0, 0, 0, -2, 0, 0, 0);
    chk("R1 default first", m_first, ef);
    chk("R1 default last", m_last, el);
    chk("R1 default rdy", m_rdy, er);

    // table walk: R2 R3 R4 R5 R9 R11
    foreach (VEC[i]) begin
      wcfg(1'b0, int'(VEC[i][15:8]));
      wcfg(1'b1, int'(VEC[i][7:0]));
      expect_t(int'(VEC[i][19:18]), int'(VEC[i][16]), ef, el, er, eh, eb, ho);
      run_cycle(int'(VEC[i][19:18]), int'(VEC[i][17]), int'(VEC[i][16]), -2, 0, 0, 0);
      chk("R2 ale width", m_ale, P);
      chk("R2 ale once", m_ale_late, 0);
      chk("R3 cmd start", m_first, ef);
      chk("R4 cmd end", m_last, el);
      chk("R5/R9 rdy time", m_rdy, er);
      chk("R5 rdy single", m_rdycnt, 1);
      chk("R11 direction", VEC[i][17] ? m_rd : m_wr, 0);
      chk("R11 active count", VEC[i][17] ? m_wr : m_rd, el - ef + 1);
    end

    // R6: iochrdy low stretches; 16-bit mem, cd 0, ws 0
    wcfg(1'b0, 8'h00);
    wcfg(1'b1, 8'h00);
    run_cycle(2, 0, 1, 9, 0, 0, 0);
    chk("R6 stretched last", m_last, 9);
    chk("R6 stretched rdy", m_rdy, 12);

    // R7: 0WS ends after one active half; 8-bit mem cd 1, ws 4
    wcfg(1'b0, 8'h04);
    wcfg(1'b1, 8'h02);
    run_cycle(1, 0, 0, -2, 1, 0, 0);
    chk("R7 early first", m_first, 4);
    chk("R7 early last", m_last, 5);
    chk("R7 early rdy", m_rdy, 8);

    // R8: iochrdy low overrides 0WS; release at 25
    run_cycle(1, 1, 0, 25, 1, 0, 0);
    chk("R8 prio first", m_first, 4);
    chk("R8 prio last", m_last, 25);
    chk("R8 prio rdy", m_rdy, 28);

    // R10: write during the cycle (hold on, ws8 5) not used until next cycle
    expect_t(1, 0, ef, el, er, eh, eb, ho);
    run_cycle(1, 0, 0, -2, 0, 0, 1);
    chk("R10 same cycle last", m_last, el);
    chk("R10 same cycle rdy", m_rdy, er);
    b_r1 = 8'h13;
    expect_t(1, 0, ef, el, er, eh, eb, ho);
    run_cycle(1, 0, 0, -2, 0, 0, 0);
    chk("R10 next cycle last", m_last, el);
    chk("R10 next cycle rdy", m_rdy, er);

    // R12: second request while busy ignored
    run_cycle(1, 0, 0, -2, 0, 1, 0);
    chk("R12 no second ale", m_ale_late, 0);
    chk("R12 rdy time", m_rdy, er);
    chk("R12 one rdy", m_rdycnt, 1);

    // R1: reset restores defaults
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    b_r0 = 8'h05; b_r1 = 8'h06;
    expect_t(2, 1, ef, el, er, eh, eb, ho);
    run_cycle(2, 1, 1, -2, 0, 0, 0);
    chk("R1 reset default first", m_first, ef);
    chk("R1 reset default rdy", m_rdy, er);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule